// File: doc/BRIEF.md
# Serial Prefix-Code Symbol Decoder

This block takes a serial stream, one code bit per clock, written with a fixed four-symbol prefix code of unequal lengths. It steps through the code tree as bits arrive. When a code word completes, it raises one bit of a 4-bit one-hot output for exactly one cycle. The stream has no framing, no valid strobe and no gaps, so code words follow one another directly.

The output is a Moore output: it depends only on the registered state. A symbol therefore shows in the clock period after its last bit was sampled. Each state that reports a symbol also acts as the tree root. The bit sampled while a symbol is shown is taken as the first bit of the next word, so decoding never stalls.

Top module: `prefix_sym_decoder`

## Requirements
- R1: The single bit 1, taken at the tree root, decodes as symbol D and drives the output to 4'b0001.
- R2: The two bits 0 then 1 decode as symbol C and drive the output to 4'b0010.
- R3: The three bits 0, 0, 0 decode as symbol A and drive the output to 4'b1000.
- R4: The three bits 0, 0, 1 decode as symbol B and drive the output to 4'b0100.
- R5: In any cycle that does not report a completed symbol the output is 4'b0000, and at no time is more than one output bit set.
- R6: A symbol indication appears in the cycle directly after the clock edge that sampled its final bit. It lasts exactly one cycle unless a single-bit D word completes on the next edge.
- R7: The bit sampled while a symbol is being reported is the first bit of the next code word, so back-to-back code words decode with no idle cycle.
- R8: Reset is synchronous and active high and takes priority over the data input. After a reset edge the output is 4'b0000, any partial code word is discarded, and the next bit starts a new word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one code bit sampled on each rising edge |
| rst | input | 1 | Synchronous active-high reset to the tree root |
| bit_i | input | 1 | Serial code bit, first bit of each word first |
| sym_o | output | 4 | One-hot symbol flag: [3]=A, [2]=B, [1]=C, [0]=D |

## Verification
The assertions assume that the serial input is a known 0 or 1 on every sampled edge once reset has been released. They also assume that reset is held high from time zero until the first edge, so the state register never starts unknown. The stimulus keeps to these assumptions. It drives the data bit and reset only shortly after each rising edge, starts with reset high, and never leaves the input undriven. Mid-word resets are applied with the data bit set to a value that would otherwise complete a symbol, so the priority of reset over data is visible at the output.

// File: rtl/prefix_sym_decoder.sv
module prefix_sym_decoder (
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_i,
  output logic [3:0] sym_o
);

  localparam int NSYM = 4;
  localparam int SW   = 3;

  typedef enum logic [SW-1:0] {
    S_ROOT = 3'd0,
    S_Z    = 3'd1,
    S_ZZ   = 3'd2,
    S_A    = 3'd3,
    S_B    = 3'd4,
    S_C    = 3'd5,
    S_D    = 3'd6
  } state_t;

  state_t state, state_nx;

  logic at_root;
  assign at_root = (state == S_ROOT) || (state == S_A) || (state == S_B) ||
                   (state == S_C) || (state == S_D);

  always_comb begin
    state_nx = state;
    if (at_root)
      state_nx = bit_i ? S_D : S_Z;
    else if (state == S_Z)
      state_nx = bit_i ? S_C : S_ZZ;
    else if (state == S_ZZ)
      state_nx = bit_i ? S_B : S_A;
    else
      state_nx = S_ROOT;
  end

  always_ff @(posedge clk) begin
    if (rst) state <= S_ROOT;
    else     state <= state_nx;
  end

  always_comb begin
    sym_o = '0;
    case (state)
      S_A:     sym_o = NSYM'(4'b1000);
      S_B:     sym_o = NSYM'(4'b0100);
      S_C:     sym_o = NSYM'(4'b0010);
      S_D:     sym_o = NSYM'(4'b0001);
      default: sym_o = '0;
    endcase
  end

  p_d_word_r1: assert property (@(posedge clk) disable iff (rst)
    (at_root && bit_i) |=> (sym_o == 4'b0001));

  p_c_word_r2: assert property (@(posedge clk) disable iff (rst)
    (state == S_Z && bit_i) |=> (sym_o == 4'b0010));

  p_a_word_r3: assert property (@(posedge clk) disable iff (rst)
    (state == S_ZZ && !bit_i) |=> (sym_o == 4'b1000));

  p_b_word_r4: assert property (@(posedge clk) disable iff (rst)
    (state == S_ZZ && bit_i) |=> (sym_o == 4'b0100));

  p_onehot_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sym_o));

  p_single_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    ((sym_o != 4'b0000) && !bit_i) |=> (sym_o == 4'b0000));

  p_no_idle_r7: assert property (@(posedge clk) disable iff (rst)
    ((sym_o != 4'b0000) && bit_i) |=> (sym_o == 4'b0001));

endmodule

// File: tb/prefix_sym_decoder_bench.sv
`timescale 1ns/1ps
module prefix_sym_decoder_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_i = 1'b0;
  logic [3:0] sym_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  prefix_sym_decoder u_prefix_sym_decoder (
    .clk  (clk),
    .rst  (rst),
    .bit_i(bit_i),
    .sym_o(sym_o)
  );

  task automatic check(input logic [3:0] exp, input string req);
    checks++;
    if (sym_o !== exp) begin
      errors++;
      $display("FAIL %s: sym_o=%b expected=%b at %0t", req, sym_o, exp, $time);
    end
  endtask

  task automatic push(input logic b, input logic [3:0] exp, input string req);
    bit_i = b;
    @(posedge clk);
    #1;
    check(exp, req);
  endtask

  task automatic send_sym(input int s, input string req);
    case (s)
      0: begin push(1'b0, 4'b0000, req); push(1'b0, 4'b0000, req); push(1'b0, 4'b1000, req); end
      1: begin push(1'b0, 4'b0000, req); push(1'b0, 4'b0000, req); push(1'b1, 4'b0100, req); end
      2: begin push(1'b0, 4'b0000, req); push(1'b1, 4'b0010, req); end
      default: push(1'b1, 4'b0001, req);
    endcase
  endtask

  task automatic t_reset;
    rst = 1'b1;
    bit_i = 1'b1;
    @(posedge clk); #1;
    @(posedge clk); #1;
    check(4'b0000, "R8 reset state");
    rst = 1'b0;
  endtask

  task automatic t_each_symbol;
    send_sym(3, "R1 D");
    push(1'b0, 4'b0000, "R6 pulse ends");
    push(1'b1, 4'b0010, "R2 C");
    push(1'b0, 4'b0000, "R6 pulse ends");
    push(1'b0, 4'b0000, "R5 partial");
    push(1'b0, 4'b1000, "R3 A");
    push(1'b0, 4'b0000, "R6 pulse ends");
    push(1'b0, 4'b0000, "R5 partial");
    push(1'b1, 4'b0100, "R4 B");
  endtask

  task automatic t_back_to_back;
    send_sym(3, "R7 D");
    send_sym(3, "R6 D held by next D");
    send_sym(3, "R7 D");
    send_sym(0, "R7 A after D");
    send_sym(1, "R7 B after A");
    send_sym(2, "R7 C after B");
    send_sym(0, "R7 A after C");
    send_sym(3, "R7 D after A");
  endtask

  task automatic t_reset_mid_word;
    push(1'b0, 4'b0000, "R5 partial");
    push(1'b0, 4'b0000, "R5 partial");
    rst = 1'b1;
    push(1'b1, 4'b0000, "R8 reset over data");
    rst = 1'b0;
    push(1'b1, 4'b0001, "R8 fresh word D");
    push(1'b0, 4'b0000, "R5 partial");
    rst = 1'b1;
    push(1'b1, 4'b0000, "R8 reset over data");
    rst = 1'b0;
    push(1'b0, 4'b0000, "R8 partial discarded");
    push(1'b1, 4'b0010, "R8 fresh word C");
  endtask

  task automatic t_stream;
    logic [7:0] lfsr = 8'hA5;
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      send_sym(int'(lfsr[1:0]), "R7 stream");
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: run did not end, actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    t_each_symbol();
    t_back_to_back();
    t_reset_mid_word();
    t_stream();
    t_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule